// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Transmitter with Fault Flags

This block sends parallel words out one bit at a time. A host places a word in a holding register with a single-cycle write strobe. When an external frame-sync pulse is seen on a rising edge of the external bit clock, the held word moves into a shift register. It then leaves on the serial data pin, most significant bit first, one bit for each later bit-clock rising edge. Both the bit clock and the frame sync are asynchronous inputs. They are resynchronized into the system clock domain, and each rising bit-clock edge becomes a one-cycle bit tick.

Three fault conditions set sticky flags, and the host clears each flag on its own with a clear mask:

- **Overwrite:** a second host write arrives before the held word was taken. The earlier word is lost.
- **Underflow:** a frame starts while no fresh word is held. The previous word is sent again.
- **Early sync:** a frame sync arrives while the current word still has more than its last bit left. Unless the ignore control is set, the current transfer is aborted and restarted from the first bit, using the fresh word if there is one.

A ready output shows whether the holding register may be written without loss.

Top module: `serial_tx_err`

## Requirements
- R1: While and directly after synchronous reset, `dout` is 0, `ready` is 1 and `ovr_err`, `und_err` and `sync_err` are 0.
- R2: A frame sync that is acted on copies the held word into the shift register. The W bits then appear on `dout`, MSB first, and each bit is valid from one bit tick until the next. After the last bit, `dout` returns to 0. A frame sync on the bit tick that ends the last bit starts the next word back to back and is not an error.
- R3: `ready` goes low on a host write and high on a copy into the shift register. When a write and a copy fall in the same cycle, the copy takes the older word, the new word is kept, `ready` stays low and no overwrite is flagged.
- R4: A host write while `ready` is low sets `ovr_err` (flag bit 0 of `clr_flags`). The overwritten word is never transmitted, and the newest word is sent at the next frame.
- R5: A frame sync acted on while `ready` is high sets `und_err` (bit 1) and sends the previous word again. This repeats on every such frame until a new word is written.
- R6: With `ign_sync` = 0, a frame sync that arrives while more than one bit of the current word remains sets `sync_err` (bit 2). It restarts transmission from the MSB: of the new word if one was written since the last copy, otherwise of the same word.
- R7: With `ign_sync` = 1, such a mid-word frame sync is ignored. The current word completes unchanged and no flag is set.
- R8: Each fault flag stays high until the matching `clr_flags` bit is pulsed. Clearing one flag leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per word |
| wr_data | input | W | Word to be transmitted |
| bclk | input | 1 | External bit clock, rising edge advances a bit |
| fsync | input | 1 | External frame-sync level, sampled with each bit clock rise |
| ign_sync | input | 1 | 1: ignore frame syncs that arrive mid-word |
| clr_flags | input | 3 | Clear mask: bit0 overwrite, bit1 underflow, bit2 sync error |
| dout | output | 1 | Serial data, MSB first, 0 when idle |
| ready | output | 1 | Holding register empty (contents already copied) |
| ovr_err | output | 1 | Sticky overwrite flag |
| und_err | output | 1 | Sticky underflow flag |
| sync_err | output | 1 | Sticky early frame-sync flag |

## Verification
A host write and a copy into the shift register can fall in the same system-clock cycle. The bench provokes this by raising the write strobe in exactly the cycle in which the synchronized bit-clock edge acts on a frame sync. It then requires that the older word is shifted out, that `ready` stays low, that no overwrite is flagged, and that the following frame sends the new word without an underflow. An early frame sync can also coincide with the underflow check. Aborting a word that has no fresh data behind it must therefore raise both the sync and the underflow flags, and the bench compares every serial bit against its own model.

// File: rtl/txe_pkg.sv
// Shared definitions for the serial transmitter: flag indices and count.
package txe_pkg;
    localparam int NFLAG = 3;
    typedef enum int {
        FLG_OVR  = 0,
        FLG_UND  = 1,
        FLG_SYNC = 2
    } flag_idx_e;
endpackage

// File: rtl/txe_edge.sv
// Resynchronizes the bit clock and frame sync into the system clock domain.
// Emits a one-cycle tick on each bit-clock rising edge, together with the
// frame-sync level that was captured alongside it.
// Assumes bclk is much slower than clk (at least four clk cycles per phase).
module txe_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    output logic tick,
    output logic fs
);
    logic [SYNC-1:0][1:0] stg;
    logic                 prev;

    // Shift both inputs through the synchronizer chain and remember the last bclk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg  <= '0;
            prev <= 1'b0;
        end else begin
            stg[0] <= {fsync, bclk};
            for (int i = 1; i < SYNC; i++) begin
                stg[i] <= stg[i-1];
            end
            prev <= stg[SYNC-1][0];
        end
    end

    // A rising synchronized bclk forms the bit tick.
    always_comb begin
        tick = stg[SYNC-1][0] & ~prev;
        fs   = stg[SYNC-1][1];
    end

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/txe_hold.sv
// Host-side holding register. Keeps the last written word and a pending bit
// meaning "written since the last copy". Reports an overwrite when a write
// lands on a pending word that is not being copied in the same cycle.
// Assumes copy is a single-cycle pulse from the shifter.
module txe_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         copy,
    output logic [W-1:0] hold_q,
    output logic         pend_q,
    output logic         ovr_set
);
    // Capture host data; the register keeps its word for later resends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end
    end

    // Pending bit: a write sets it (and wins over a copy), a copy clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_en) begin
            pend_q <= 1'b1;
        end else if (copy) begin
            pend_q <= 1'b0;
        end
    end

    // Overwrite only when the pending word is not being taken right now.
    always_comb begin
        ovr_set = wr_en & pend_q & ~copy;
    end

    assert_write_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pend_q);
    assert_copy_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (copy && !wr_en) |=> !pend_q);
    assert_write_keeps_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (hold_q == $past(wr_data)));
endmodule

// File: rtl/txe_shift.sv
// Shift register and bit counter. Decides on each bit tick whether a frame
// sync is acted on: always when idle or on the last bit, and mid-word only
// when ign_sync is 0. An acted-on sync reloads from the holding register,
// which covers the new word, the underflow resend and the abort restart.
// Assumes tick is a single-cycle pulse.
module txe_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         fs,
    input  logic         ign_sync,
    input  logic         pend_q,
    input  logic [W-1:0] hold_q,
    output logic         copy,
    output logic         dout,
    output logic         und_set,
    output logic         sync_set
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;
    logic          mid;

    // Frame decision: mid-word means more than the final bit is still due.
    always_comb begin
        mid      = (cnt > CW'(1));
        copy     = tick & fs & (~mid | ~ign_sync);
        und_set  = copy & ~pend_q;
        sync_set = copy & mid;
        dout     = (cnt != '0) & sh[W-1];
    end

    // Load on an acted-on sync, otherwise shift one bit per tick while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (copy) begin
            sh  <= hold_q;
            cnt <= CW'(W);
        end else if (tick && cnt != '0) begin
            sh  <= {sh[W-2:0], 1'b0};
            cnt <= cnt - CW'(1);
        end
    end

    assert_load_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        copy |=> (dout == $past(hold_q[W-1])));
    assert_abort_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fs && mid && !ign_sync) |=> (cnt == CW'(W)));
    assert_ignore_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fs && mid && ign_sync) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/txe_flags.sv
// Sticky fault flags, one per index of the package enumeration.
// A set in the same cycle as a clear keeps the flag high.
module txe_flags
    import txe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] q
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // Hold the flag once set until its clear bit arrives.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= 1'b0;
            end else if (set[g]) begin
                q[g] <= 1'b1;
            end else if (clr[g]) begin
                q[g] <= 1'b0;
            end
        end

        assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> q[g]);
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (q[g] && !clr[g]) |=> q[g]);
    end
endmodule

// File: rtl/serial_tx_err.sv
// Top of the serial transmitter: ties the bit-clock synchronizer, holding
// register, shifter and sticky flags together.
// Assumes wr_en is a clk-domain strobe and that bclk and fsync are external.
module serial_tx_err
    import txe_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             bclk,
    input  logic             fsync,
    input  logic             ign_sync,
    input  logic [NFLAG-1:0] clr_flags,
    output logic             dout,
    output logic             ready,
    output logic             ovr_err,
    output logic             und_err,
    output logic             sync_err
);
    logic             tick, fs, copy, pend_q, ovr_set, und_set, sync_set;
    logic [W-1:0]     hold_q;
    logic [NFLAG-1:0] fset, fq;

    txe_edge #(.SYNC(SYNC)) u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .tick(tick), .fs(fs)
    );

    txe_hold #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .copy(copy), .hold_q(hold_q), .pend_q(pend_q), .ovr_set(ovr_set)
    );

    txe_shift #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fs(fs), .ign_sync(ign_sync),
        .pend_q(pend_q), .hold_q(hold_q), .copy(copy), .dout(dout),
        .und_set(und_set), .sync_set(sync_set)
    );

    // Gather flag set requests in enumeration order.
    always_comb begin
        fset           = '0;
        fset[FLG_OVR]  = ovr_set;
        fset[FLG_UND]  = und_set;
        fset[FLG_SYNC] = sync_set;
    end

    txe_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set(fset), .clr(clr_flags), .q(fq)
    );

    // Drive status outputs.
    always_comb begin
        ready    = ~pend_q;
        ovr_err  = fq[FLG_OVR];
        und_err  = fq[FLG_UND];
        sync_err = fq[FLG_SYNC];
    end

    assert_ready_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ready);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!dout && ready && !ovr_err && !und_err && !sync_err));
endmodule

// File: tb/tb_serial_tx_err.sv
// Scoreboard bench: a driver task runs a bench-side model per bit tick and
// pushes the expected serial bit; a monitor pops it at the next bclk rise.
module tb_serial_tx_err;
    localparam int W = 8;

    logic         clk = 0, rst_n = 0, wr_en = 0, bclk = 0, fsync = 0, ign_sync = 0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   clr_flags = '0;
    logic         dout, ready, ovr_err, und_err, sync_err;

    int total = 0, bad = 0;
    bit done = 0;

    bit     exp_q[$];
    string  tag_q[$];

    // bench model state
    logic [W-1:0] m_hold = '0, m_sh = '0;
    int           m_cnt = 0;
    bit           m_pend = 0, m_ovr = 0, m_und = 0, m_sync = 0;

    serial_tx_err #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .bclk(bclk),
        .fsync(fsync), .ign_sync(ign_sync), .clr_flags(clr_flags), .dout(dout),
        .ready(ready), .ovr_err(ovr_err), .und_err(und_err), .sync_err(sync_err)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare dout against the expectation of the last tick
    always @(posedge bclk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(dout), int'(e));
        end
    end

    task automatic model_write(input logic [W-1:0] d);
        if (m_pend) m_ovr = 1;
        m_hold = d;
        m_pend = 1;
    endtask

    task automatic host_write(input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_write(d);
    endtask

    // one bit-clock period; cw places a host write in the copy cycle
    task automatic bit_cycle(input bit fs, input bit cw, input logic [W-1:0] d,
                             input string tag);
        bit mid, act;
        @(negedge clk);
        fsync = fs; bclk = 1;
        @(negedge clk);
        @(negedge clk);
        if (cw) begin wr_en = 1; wr_data = d; end
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        bclk = 0; fsync = 0;
        mid = (m_cnt > 1);
        act = fs && (!mid || !ign_sync);
        if (act) begin
            if (mid) m_sync = 1;
            if (!m_pend) m_und = 1;
            m_sh = m_hold; m_cnt = W; m_pend = 0;
        end else if (m_cnt != 0) begin
            m_sh = {m_sh[W-2:0], 1'b0};
            m_cnt--;
        end
        if (cw) model_write(d);
        exp_q.push_back((m_cnt != 0) ? m_sh[W-1] : 1'b0);
        tag_q.push_back(tag);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_bits(input int n, input string tag);
        for (int i = 0; i < n; i++) bit_cycle(0, 0, '0, tag);
    endtask

    task automatic check_status(input string tag);
        @(negedge clk);
        check({tag, " ready"}, int'(ready), int'(!m_pend));
        check({tag, " flags"}, int'({sync_err, und_err, ovr_err}),
              int'({m_sync, m_und, m_ovr}));
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk);
        clr_flags = m;
        @(negedge clk);
        clr_flags = '0;
        if (m[0]) m_ovr = 0;
        if (m[1]) m_und = 0;
        if (m[2]) m_sync = 0;
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 dout reset", int'(dout), 0);
        check("R1 ready reset", int'(ready), 1);
        check("R1 flags reset", int'({sync_err, und_err, ovr_err}), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", int'({dout, ready, sync_err, und_err, ovr_err}), 8);

        // R2/R3: normal word, then a back-to-back frame
        host_write(8'hA5);
        check_status("R3 write");
        bit_cycle(1, 0, '0, "R2 word A5");
        check_status("R3 copy");
        run_bits(3, "R2 word A5");
        host_write(8'h3C);
        run_bits(4, "R2 word A5");
        bit_cycle(1, 0, '0, "R2 back-to-back 3C");
        run_bits(7, "R2 word 3C");
        run_bits(2, "R2 idle");
        check_status("R2 no error");

        // R5: underflow twice, then R8 clear
        bit_cycle(1, 0, '0, "R5 resend 3C");
        run_bits(7, "R5 resend 3C");
        bit_cycle(1, 0, '0, "R5 resend again");
        run_bits(8, "R5 resend again");
        check_status("R5 underflow");
        check_status("R8 sticky");
        clear(3'b010);
        check_status("R8 clear und");

        // R4: overwrite
        host_write(8'h11);
        host_write(8'h22);
        check_status("R4 overwrite");
        bit_cycle(1, 0, '0, "R4 sends 22");
        run_bits(8, "R4 sends 22");
        clear(3'b001);
        check_status("R8 clear ovr");

        // R6: abort with a new word pending
        host_write(8'h0F);
        bit_cycle(1, 0, '0, "R6 word 0F");
        run_bits(2, "R6 word 0F");
        host_write(8'hF0);
        bit_cycle(1, 0, '0, "R6 restart F0");
        run_bits(7, "R6 restart F0");
        check_status("R6 abort pending");
        // R6: abort with nothing pending restarts the same word
        bit_cycle(1, 0, '0, "R6 word F0");
        run_bits(1, "R6 word F0");
        bit_cycle(1, 0, '0, "R6 same restart");
        run_bits(8, "R6 same restart");
        check_status("R6 abort same");
        clear(3'b111);
        check_status("R8 clear all");

        // R7: ignored mid-word sync
        ign_sync = 1;
        host_write(8'h55);
        bit_cycle(1, 0, '0, "R7 word 55");
        run_bits(3, "R7 word 55");
        bit_cycle(1, 0, '0, "R7 ignored sync");
        run_bits(5, "R7 completes");
        check_status("R7 no flag");
        ign_sync = 0;

        // R3: write in the copy cycle
        host_write(8'h99);
        bit_cycle(1, 1, 8'h66, "R3 collide sends 99");
        run_bits(7, "R3 collide sends 99");
        check_status("R3 collide");
        bit_cycle(1, 0, '0, "R3 then 66");
        run_bits(8, "R3 then 66");
        check_status("R3 after collide");

        @(negedge clk);
        bclk = 1;
        repeat (2) @(negedge clk);
        check("R2 queue drained", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule